// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block tracks exception conditions for the instructions flowing through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). A fault found in any stage is not acted on when it is detected. It is recorded against the instruction that caused it and carried forward alongside that instruction's PC. The fault is resolved only when the instruction reaches the memory stage, which is the single commit point. Because of this, the exception the handler sees is always precise: every older instruction has completed, and nothing younger has touched architectural state.

At the commit point, the block makes one decision per cycle. It picks the highest-priority event for the instruction sitting there: an enabled external interrupt, or the earliest-detected synchronous fault. When it takes an event, it records a cause code and the instruction's PC, flushes every younger stage, suppresses the instruction's own writeback, and steers fetch to a fixed handler address. At the same time it switches to kernel mode with interrupts masked. A return-from-exception instruction at commit reverses the mode change and steers fetch back to the saved PC.

Top module: `exc_commit_ctrl`

## Requirements
- R1: After reset, flush_o and redirect_o are low, int_en_o is 0, kernel_o is 1, and cause_o and epc_o are 0.
- R2: An exception detected in fetch, decode or execute produces no flush while the faulting instruction is still in that stage. The flush fires in the cycle that instruction occupies the memory stage: three cycles after it was presented at fetch with no stall.
- R3: When one instruction collects several faults, the earliest stage's fault decides cause_o. The codes are fetch address fault = 0, illegal opcode = 1, overflow = 2 and data address fault = 3.
- R4: An enabled external interrupt taken at commit beats any synchronous fault of the same instruction and records cause code 8.
- R5: When an event is taken, the cycle after the flush shows epc_o equal to the PC of the instruction that was at commit, and cause_o equal to the chosen code.
- R6: In a take cycle, flush_o and redirect_o are high, redirect_pc_o equals HANDLER_PC (default 32'h0000_0100), and commit_o is low. No instruction that was in fetch, decode or execute in that cycle ever reaches commit.
- R7: A take clears int_en_o and sets kernel_o from the next cycle on.
- R8: A valid return-from-exception at commit with no event taken sets int_en_o to 1 and kernel_o to 0 in the next cycle. In the same cycle it raises flush_o and redirect_o with redirect_pc_o equal to epc_o.
- R9: irq_req has no effect when int_en_o is 0 or when the memory stage holds a bubble.
- R10: A bubble never raises an exception. Fault inputs sampled while their stage holds no valid instruction are discarded, and commit_o is high exactly when a valid instruction sits at commit and no event is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetch stage holds a valid instruction |
| if_pc | input | PC_W | PC of the fetched instruction |
| if_fault | input | 1 | Fetch address fault for the fetched instruction |
| id_illegal | input | 1 | Illegal opcode for the instruction in decode |
| ex_ovf | input | 1 | Arithmetic overflow for the instruction in execute |
| mem_dfault | input | 1 | Data address fault for the instruction in memory |
| mem_rfe | input | 1 | Instruction in memory is a return-from-exception |
| irq_req | input | 1 | External interrupt request |
| commit_o | output | 1 | Instruction at memory stage commits this cycle |
| flush_o | output | 1 | Kill fetch, decode, execute and writeback this cycle |
| redirect_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | PC_W | Restart address for fetch |
| cause_o | output | 4 | Recorded cause code |
| epc_o | output | PC_W | Recorded PC of the interrupted instruction |
| int_en_o | output | 1 | Interrupts enabled |
| kernel_o | output | 1 | Kernel mode active |

## Verification
The bench targets the following cases:
- An instruction with a fetch fault that also overflows later. A design that let later stages overwrite the flag would report cause 2 instead of 0.
- An interrupt arriving together with a data fault. A design without interrupt priority would record cause 3.
- Interrupts raised while masked or over a bubble. Sampling them there would cause spurious flushes.
- Fault inputs asserted while their stage holds a bubble.
- Instructions sitting behind a taken event, which must never commit.
- Return-from-exception, which must restore user mode and point fetch back at the saved PC.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int CAUSE_W = 4;
   typedef logic [CAUSE_W-1:0] cause_t;
   localparam cause_t C_FETCH   = 4'd0;
   localparam cause_t C_ILLEGAL = 4'd1;
   localparam cause_t C_OVF     = 4'd2;
   localparam cause_t C_DADDR   = 4'd3;
   localparam cause_t C_IRQ     = 4'd8;
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
   import exc_pkg::*;
#(
   parameter int     PC_W        = 32,
   parameter cause_t LOCAL_CAUSE = C_FETCH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kill,
   input  logic            in_valid,
   input  logic [PC_W-1:0] in_pc,
   input  logic            in_exc,
   input  cause_t          in_cause,
   input  logic            detect,
   output logic            out_valid,
   output logic [PC_W-1:0] out_pc,
   output logic            out_exc,
   output cause_t          out_cause
);
   // An older (earlier-stage) flag is kept; the local one only fills an empty slot.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pc    <= '0;
         out_exc   <= 1'b0;
         out_cause <= C_FETCH;
      end else if (kill) begin
         out_valid <= 1'b0;
         out_exc   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_pc    <= in_pc;
         out_exc   <= in_valid & (in_exc | detect);
         out_cause <= in_exc ? in_cause : LOCAL_CAUSE;
      end
   end
endmodule

// File: rtl/exc_commit_resolve.sv
module exc_commit_resolve
   import exc_pkg::*;
(
   input  logic   m_valid,
   input  logic   m_exc,
   input  cause_t m_cause,
   input  logic   mem_dfault,
   input  logic   mem_rfe,
   input  logic   irq_req,
   input  logic   int_en,
   output logic   take,
   output logic   take_irq,
   output logic   rfe_go,
   output cause_t take_cause
);
   logic sync_hit;

   always_comb begin
      sync_hit   = m_valid & (m_exc | mem_dfault);
      take_irq   = m_valid & int_en & irq_req;
      take       = take_irq | sync_hit;
      rfe_go     = m_valid & mem_rfe & ~take;
      if (take_irq)   take_cause = C_IRQ;
      else if (m_exc) take_cause = m_cause;
      else            take_cause = C_DADDR;
   end
endmodule

// File: rtl/exc_arch_state.sv
module exc_arch_state
   import exc_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  cause_t          take_cause,
   input  logic            rfe_go,
   input  logic [PC_W-1:0] m_pc,
   output logic [PC_W-1:0] epc,
   output cause_t          cause,
   output logic            int_en,
   output logic            kernel
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc    <= '0;
         cause  <= C_FETCH;
         int_en <= 1'b0;
         kernel <= 1'b1;
      end else if (take) begin
         epc    <= m_pc;
         cause  <= take_cause;
         int_en <= 1'b0;
         kernel <= 1'b1;
      end else if (rfe_go) begin
         int_en <= 1'b1;
         kernel <= 1'b0;
      end
   end
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
   import exc_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = 'h100
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            if_valid,
   input  logic [PC_W-1:0] if_pc,
   input  logic            if_fault,
   input  logic            id_illegal,
   input  logic            ex_ovf,
   input  logic            mem_dfault,
   input  logic            mem_rfe,
   input  logic            irq_req,
   output logic            commit_o,
   output logic            flush_o,
   output logic            redirect_o,
   output logic [PC_W-1:0] redirect_pc_o,
   output logic [3:0]      cause_o,
   output logic [PC_W-1:0] epc_o,
   output logic            int_en_o,
   output logic            kernel_o
);
   localparam int N_HOPS = 3;  // fetch->decode, decode->execute, execute->memory

   function automatic cause_t hop_cause(int i);
      case (i)
         0:       return C_FETCH;
         1:       return C_ILLEGAL;
         default: return C_OVF;
      endcase
   endfunction

   if (PC_W < 8 || PC_W > 64) begin : g_bad_pc_w
      $error("exc_commit_ctrl: PC_W out of range");
   end
   if (CAUSE_W != 4) begin : g_bad_cause_w
      $error("exc_commit_ctrl: cause width must be 4");
   end

   logic            sv    [N_HOPS+1];
   logic [PC_W-1:0] spc   [N_HOPS+1];
   logic            sexc  [N_HOPS+1];
   cause_t          scause[N_HOPS+1];
   logic            det   [N_HOPS];

   logic   take, take_irq, rfe_go, flush;
   cause_t take_cause, cause_q;

   assign sv[0]     = if_valid;
   assign spc[0]    = if_pc;
   assign sexc[0]   = 1'b0;
   assign scause[0] = C_FETCH;
   assign det[0]    = if_fault;
   assign det[1]    = id_illegal;
   assign det[2]    = ex_ovf;

   for (genvar g = 0; g < N_HOPS; g++) begin : g_hop
      exc_stage_reg #(.PC_W(PC_W), .LOCAL_CAUSE(hop_cause(g))) u_reg (
         .clk      (clk),
         .rst_n    (rst_n),
         .kill     (flush),
         .in_valid (sv[g]),
         .in_pc    (spc[g]),
         .in_exc   (sexc[g]),
         .in_cause (scause[g]),
         .detect   (det[g]),
         .out_valid(sv[g+1]),
         .out_pc   (spc[g+1]),
         .out_exc  (sexc[g+1]),
         .out_cause(scause[g+1])
      );
   end

   logic            m_valid;
   logic [PC_W-1:0] m_pc;
   assign m_valid = sv[N_HOPS];
   assign m_pc    = spc[N_HOPS];

   exc_commit_resolve u_resolve (
      .m_valid   (m_valid),
      .m_exc     (sexc[N_HOPS]),
      .m_cause   (scause[N_HOPS]),
      .mem_dfault(mem_dfault),
      .mem_rfe   (mem_rfe),
      .irq_req   (irq_req),
      .int_en    (int_en_o),
      .take      (take),
      .take_irq  (take_irq),
      .rfe_go    (rfe_go),
      .take_cause(take_cause)
   );

   exc_arch_state #(.PC_W(PC_W)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .take_cause(take_cause),
      .rfe_go    (rfe_go),
      .m_pc      (m_pc),
      .epc       (epc_o),
      .cause     (cause_q),
      .int_en    (int_en_o),
      .kernel    (kernel_o)
   );

   assign flush         = take | rfe_go;
   assign flush_o       = flush;
   assign redirect_o    = flush;
   assign redirect_pc_o = take ? HANDLER_PC : epc_o;
   assign commit_o      = m_valid & ~take;
   assign cause_o       = cause_q;
endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = 'h100
) (
   input logic            clk,
   input logic            rst_n,
   input logic            take,
   input logic            take_irq,
   input logic            rfe_go,
   input logic            m_valid,
   input logic [PC_W-1:0] m_pc,
   input logic            flush_o,
   input logic            commit_o,
   input logic [PC_W-1:0] redirect_pc_o,
   input logic [3:0]      cause_o,
   input logic [PC_W-1:0] epc_o,
   input logic            int_en_o,
   input logic            kernel_o
);
   a_r6_take_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (flush_o && !commit_o && redirect_pc_o == HANDLER_PC));

   a_r6_flush_empties_commit: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> !m_valid);

   a_r5_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> epc_o == $past(m_pc));

   a_r7_take_masks: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!int_en_o && kernel_o));

   a_r8_rfe_restores: assert property (@(posedge clk) disable iff (!rst_n)
      rfe_go |=> (int_en_o && !kernel_o));

   a_r8_rfe_target: assert property (@(posedge clk) disable iff (!rst_n)
      rfe_go |-> (flush_o && redirect_pc_o == epc_o));

   a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |=> cause_o == 4'd8);

   a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> (int_en_o && m_valid));

   a_r10_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid |-> (!flush_o && !commit_o));
endmodule

bind exc_commit_ctrl exc_commit_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .take         (take),
   .take_irq     (take_irq),
   .rfe_go       (rfe_go),
   .m_valid      (m_valid),
   .m_pc         (m_pc),
   .flush_o      (flush_o),
   .commit_o     (commit_o),
   .redirect_pc_o(redirect_pc_o),
   .cause_o      (cause_o),
   .epc_o        (epc_o),
   .int_en_o     (int_en_o),
   .kernel_o     (kernel_o)
);

// File: tb/exc_commit_ctrl_tb.sv
module exc_commit_ctrl_tb;
   localparam int          PC_W = 32;
   localparam logic [31:0] HPC  = 32'h0000_0100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic if_valid = 0, if_fault = 0, id_illegal = 0, ex_ovf = 0;
   logic mem_dfault = 0, mem_rfe = 0, irq_req = 0;
   logic [PC_W-1:0] if_pc = '0;
   logic commit_o, flush_o, redirect_o, int_en_o, kernel_o;
   logic [PC_W-1:0] redirect_pc_o, epc_o;
   logic [3:0] cause_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HPC)) u_dut (
      .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
      .if_fault(if_fault), .id_illegal(id_illegal), .ex_ovf(ex_ovf),
      .mem_dfault(mem_dfault), .mem_rfe(mem_rfe), .irq_req(irq_req),
      .commit_o(commit_o), .flush_o(flush_o), .redirect_o(redirect_o),
      .redirect_pc_o(redirect_pc_o), .cause_o(cause_o), .epc_o(epc_o),
      .int_en_o(int_en_o), .kernel_o(kernel_o)
   );

   // reference model state, built from the requirements
   logic dv = 0, de = 0, ev = 0, ee = 0, mv = 0, me = 0;
   logic [3:0] dc = 0, ec = 0, mc = 0;
   logic [31:0] dpc = 0, epcs = 0, mpc = 0;
   logic r_int = 0, r_ker = 1;
   logic [3:0] r_cause = 0;
   logic [31:0] r_epc = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] pick_cause(logic irq_t, logic m_e, logic [3:0] m_c);
      if (irq_t) return 4'd8;
      if (m_e)   return m_c;
      return 4'd3;
   endfunction

   task automatic step(logic fv, logic [31:0] pc, logic ff, logic il, logic ov,
                       logic df, logic irq, logic rfe);
      logic irq_t, take, rfe_t;
      @(negedge clk);
      if_valid = fv; if_pc = pc; if_fault = ff; id_illegal = il;
      ex_ovf = ov; mem_dfault = df; irq_req = irq; mem_rfe = rfe;
      #1;
      irq_t = mv & r_int & irq;
      take  = irq_t | (mv & (me | df));
      rfe_t = mv & rfe & ~take;
      chk("R2 flush", flush_o, take | rfe_t);
      chk("R6 redirect", redirect_o, take | rfe_t);
      if (take)       chk("R6 handler pc", redirect_pc_o, HPC);
      else if (rfe_t) chk("R8 return pc", redirect_pc_o, r_epc);
      chk("R10 commit", commit_o, mv & ~take);
      chk("R3 cause", cause_o, r_cause);
      chk("R5 epc", epc_o, r_epc);
      chk("R7 int_en", int_en_o, r_int);
      chk("R8 kernel", kernel_o, r_ker);
      // advance model to the state after the coming edge
      if (take) begin
         r_epc = mpc; r_cause = pick_cause(irq_t, me, mc); r_int = 0; r_ker = 1;
      end else if (rfe_t) begin
         r_int = 1; r_ker = 0;
      end
      if (take | rfe_t) begin
         dv = 0; de = 0; ev = 0; ee = 0; mv = 0; me = 0;
      end else begin
         mv = ev; mpc = epcs; me = ev & (ee | ov); mc = ee ? ec : 4'd2;
         ev = dv; epcs = dpc; ee = dv & (de | il); ec = de ? dc : 4'd1;
         dv = fv; dpc = pc;   de = fv & ff;        dc = 4'd0;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   // push one instruction and walk it to commit, faults per stage, event inputs at commit
   task automatic run_one(logic [31:0] pc, logic ff, logic il, logic ov,
                          logic df, logic irq, logic rfe);
      step(1, pc, ff, 0, 0, 0, 0, 0);
      step(0, 0, 0, il, 0, 0, 0, 0);
      step(0, 0, 0, 0, ov, 0, 0, 0);
      step(0, 0, 0, 0, 0, df, irq, rfe);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values
      chk("R1 flush", flush_o, 0);
      chk("R1 redirect", redirect_o, 0);
      chk("R1 int_en", int_en_o, 0);
      chk("R1 kernel", kernel_o, 1);
      chk("R1 cause", cause_o, 0);
      chk("R1 epc", epc_o, 0);
      rst_n = 1'b1;

      // R8: return-from-exception enters user mode, jumps to epc (0)
      run_one(32'h40, 0, 0, 0, 0, 0, 1);
      chk("R8 rfe redirect pc", redirect_pc_o, 32'h0);
      idle(1);
      chk("R8 user mode", kernel_o, 0);
      chk("R8 int enabled", int_en_o, 1);

      // R2/R3: fetch fault plus later overflow, no early flush, cause 0
      step(1, 32'h200, 1, 0, 0, 0, 0, 0);
      chk("R2 no flush at fetch", flush_o, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 no flush at decode", flush_o, 0);
      step(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R2 no flush at execute", flush_o, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 flush at commit", flush_o, 1);
      idle(1);
      chk("R3 earliest wins", cause_o, 4'd0);
      chk("R5 epc of faulting", epc_o, 32'h200);

      // R3: illegal + overflow -> 1
      run_one(32'h0, 0, 0, 0, 0, 0, 1); idle(1);
      run_one(32'h300, 0, 1, 1, 1, 0, 0); idle(1);
      chk("R3 illegal beats later", cause_o, 4'd1);

      // R4: interrupt beats data fault
      run_one(32'h0, 0, 0, 0, 0, 0, 1); idle(1);
      run_one(32'h480, 0, 0, 0, 1, 1, 0);
      chk("R6 commit suppressed", commit_o, 0);
      idle(1);
      chk("R4 irq cause", cause_o, 4'd8);
      chk("R5 irq epc", epc_o, 32'h480);

      // R9: masked interrupt ignored (kernel, int_en 0)
      run_one(32'h500, 0, 0, 0, 0, 1, 0);
      chk("R9 masked irq no flush", flush_o, 0);
      chk("R9 masked irq commits", commit_o, 1);
      idle(1);
      chk("R9 cause unchanged", cause_o, 4'd8);

      // R9: enabled interrupt over a bubble at commit ignored
      run_one(32'h0, 0, 0, 0, 0, 0, 1); idle(3);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      chk("R9 bubble irq no flush", flush_o, 0);

      // R10: fault inputs over bubbles discarded
      step(0, 0, 1, 1, 1, 1, 0, 0);
      step(0, 0, 1, 1, 1, 1, 0, 0);
      step(0, 0, 1, 1, 1, 1, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0);
      chk("R10 bubble fault no flush", flush_o, 0);
      idle(1);
      chk("R10 int_en kept", int_en_o, 1);

      // R6: instructions behind a take never commit
      step(1, 32'h600, 0, 0, 0, 0, 0, 0);
      step(1, 32'h604, 0, 0, 0, 0, 0, 0);
      step(1, 32'h608, 0, 0, 1, 0, 0, 0);
      step(1, 32'h60c, 0, 0, 0, 0, 0, 0);
      chk("R6 overflow take", flush_o, 1);
      step(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R6 younger killed", commit_o, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R6 younger killed 2", commit_o, 0);
      chk("R5 epc first", epc_o, 32'h600);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 10) < 8, {$urandom} & 32'hFFFF_FFFC,
              ($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
              ($urandom % 16) == 0, ($urandom % 6) == 0, ($urandom % 8) == 0);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule